// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block sets the two thresholds that a 512-word FIFO uses for its early-warning flags. The almost-empty offset (X) and the almost-full offset (Y) are fixed once, right after reset. The way they are set is picked by three configuration pins, and those pins are sampled on the reset release. The offsets can come from three places:

- one of three built-in presets;
- the first two enabled write cycles, which are steered away from the FIFO memory while they carry the offsets;
- a serial stream of 18 bits, clocked in on the write clock while a serial enable pin is held low.

In every loading method Y is taken before X.

After loading, the block compares the FIFO occupancy count with both offsets and drives the almost-empty and almost-full flags. Until loading is complete, both flags stay low and no write reaches the FIFO memory. The reset input is synchronous and active-low. On every clock edge where it is low, the block captures the mode pins, so the value present in the last low cycle chooses the mode. Outside reset, the second and third mode pins are reused as the serial enable and the serial data.

Top module: `fifo_offset_prog`

## Requirements
- R1: The pin pattern (cfg_mode, cfg_a_en, cfg_b_dat) selects a preset. 1,1,1 gives X=Y=64, 1,1,0 gives X=Y=16, and 1,0,1 gives X=Y=8. prog_done rises on the first clock edge after reset release, and mode_err stays 0.
- R2: The patterns 0,0,0, 0,0,1 and 0,1,1 are reserved. Each of them loads X=Y=8, and prog_done and mode_err both rise on the first clock edge after release.
- R3: Pattern 1,0,0 selects parallel loading. The first clock edge with wr_en high loads Y from wr_ofs_bits, and the second such edge loads X and raises prog_done. Cycles with wr_en low change nothing.
- R4: In parallel loading, wr_ofs_bits[8] is the most significant bit of each offset and wr_ofs_bits[0] is the least significant bit.
- R5: While a parallel offset write is under way, wr_divert is high and ram_wr_en is low. The third enabled write is the first data write: ram_wr_en is high and wr_divert is low.
- R6: Pattern 0,1,0 selects serial loading. On each clock edge with cfg_a_en low, one bit is taken from cfg_b_dat. Edges with cfg_a_en high are ignored. Within each offset the bits arrive MSB first: bits 1 to 9 form Y and bits 10 to 18 form X. The 18th bit raises prog_done.
- R7: While prog_done is low, almost_empty, almost_full and ram_wr_en are all low.
- R8: After prog_done, almost_empty is high exactly when occupancy ≤ X.
- R9: After prog_done, almost_full is high exactly when occupancy ≥ 512 − Y.
- R10: While reset is low, prog_done, mode_err and both offsets are 0. The mode is taken from the pins in the last reset cycle, and the offsets stay frozen after prog_done until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-port clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| cfg_mode | input | 1 | Mode pin: high chooses presets or parallel loading |
| cfg_a_en | input | 1 | Mode pin during reset; active-low serial enable afterwards |
| cfg_b_dat | input | 1 | Mode pin during reset; serial data afterwards |
| wr_en | input | 1 | Write enable of the FIFO write port |
| wr_ofs_bits | input | 9 | Low bits of the write data bus |
| occupancy | input | 10 | Current FIFO word count, 0 to 512 |
| ofs_ae | output | 9 | Almost-empty offset X |
| ofs_af | output | 9 | Almost-full offset Y |
| prog_done | output | 1 | Offsets are loaded |
| mode_err | output | 1 | A reserved mode was sampled |
| wr_divert | output | 1 | The current write carries an offset and must not store into RAM |
| ram_wr_en | output | 1 | The current write stores into RAM |
| almost_empty | output | 1 | occupancy ≤ X |
| almost_full | output | 1 | occupancy ≥ 512 − Y |

## Verification
The bench targets the following corner cases:

- **Write ordering.** Two offset writes go in with an idle gap between them, and their values are chosen to differ. A design that swapped the Y/X order, or that counted idle cycles as writes, would hold the wrong offsets.
- **Serial stream.** The stream has a pause mid-way, during which the data pin carries a wrong bit. A design that sampled while the enable was high, or that shifted LSB first, would load scrambled offsets.
- **Flag thresholds.** Each flag is probed on both sides of its threshold, to catch an off-by-one comparison or an inverted subtraction.
- **Mode sampling.** One reset changes the mode pins partway through. A design that latched the first reset cycle instead of the last would come up with 64 instead of 8.

// File: rtl/fop_pkg.sv
// Shared types for the flag offset programming controller.
// Assumes nothing beyond the tool supporting packed enums.
package fop_pkg;

    // Loading method chosen at reset release
    typedef enum logic [1:0] {
        PM_PRESET   = 2'd0,
        PM_PARALLEL = 2'd1,
        PM_SERIAL   = 2'd2,
        PM_RESERVED = 2'd3
    } prog_mode_e;

endpackage

// File: rtl/fop_mode_decode.sv
// Decodes the three mode pins into a loading method and a preset value.
// Assumes the pins are stable around the clock edges sampled during reset.
module fop_mode_decode
    import fop_pkg::*;
#(
    parameter int OFS_W   = 9,
    parameter int DEF_HI  = 64,
    parameter int DEF_MID = 16,
    parameter int DEF_LO  = 8
) (
    input  logic             pin_mode,
    input  logic             pin_a,
    input  logic             pin_b,
    output prog_mode_e       mode,
    output logic [OFS_W-1:0] def_ofs
);

    localparam logic [OFS_W-1:0] V_HI  = OFS_W'(DEF_HI);
    localparam logic [OFS_W-1:0] V_MID = OFS_W'(DEF_MID);
    localparam logic [OFS_W-1:0] V_LO  = OFS_W'(DEF_LO);

    // Map each pin pattern to a method; reserved patterns fall back to the low preset
    always_comb begin
        mode    = PM_RESERVED;
        def_ofs = V_LO;
        unique case ({pin_mode, pin_a, pin_b})
            3'b111: begin mode = PM_PRESET;   def_ofs = V_HI;  end
            3'b110: begin mode = PM_PRESET;   def_ofs = V_MID; end
            3'b101: begin mode = PM_PRESET;   def_ofs = V_LO;  end
            3'b100: begin mode = PM_PARALLEL; def_ofs = V_LO;  end
            3'b010: begin mode = PM_SERIAL;   def_ofs = V_LO;  end
            default: begin mode = PM_RESERVED; def_ofs = V_LO; end
        endcase
    end

endmodule

// File: rtl/fop_loader.sv
// Captures the mode during reset, then loads Y and X by the chosen method.
// Assumes a synchronous active-low reset; offsets are frozen once done is set.
module fop_loader
    import fop_pkg::*;
#(
    parameter int OFS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  prog_mode_e       mode_in,
    input  logic [OFS_W-1:0] def_in,
    input  logic             ser_en_n,
    input  logic             ser_dat,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_bits,
    output prog_mode_e       mode_q,
    output logic             done_q,
    output logic             err_q,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);

    localparam int SER_BITS = 2 * OFS_W;
    localparam int CNT_W    = $clog2(SER_BITS);
    localparam int SR_W     = SER_BITS - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SER_BITS - 1);

    logic [OFS_W-1:0] def_q;
    logic             par_second;
    logic [CNT_W-1:0] bit_cnt;
    logic [SR_W-1:0]  sreg;

    // Sample mode during reset; afterwards load offsets once by the chosen method
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= mode_in;
            def_q      <= def_in;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            par_second <= 1'b0;
            bit_cnt    <= '0;
            sreg       <= '0;
            ae_q       <= '0;
            af_q       <= '0;
        end else if (!done_q) begin
            unique case (mode_q)
                PM_PRESET: begin
                    ae_q   <= def_q;
                    af_q   <= def_q;
                    done_q <= 1'b1;
                end
                PM_RESERVED: begin
                    ae_q   <= def_q;
                    af_q   <= def_q;
                    err_q  <= 1'b1;
                    done_q <= 1'b1;
                end
                PM_PARALLEL: begin
                    if (wr_en) begin
                        if (!par_second) begin
                            af_q       <= wr_bits;
                            par_second <= 1'b1;
                        end else begin
                            ae_q   <= wr_bits;
                            done_q <= 1'b1;
                        end
                    end
                end
                PM_SERIAL: begin
                    if (!ser_en_n) begin
                        sreg    <= {sreg[SR_W-2:0], ser_dat};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        if (bit_cnt == LAST_BIT) begin
                            af_q   <= sreg[SR_W-1:OFS_W-1];
                            ae_q   <= {sreg[OFS_W-2:0], ser_dat};
                            done_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fop_flags.sv
// Compares the FIFO occupancy with the two offsets to form the early flags.
// Assumes occupancy never exceeds DEPTH; flags are held low until enabled.
module fop_flags #(
    parameter int DEPTH = 512,
    parameter int OFS_W = 9,
    parameter int OCC_W = 10
) (
    input  logic             enable,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [OFS_W-1:0] ofs_ae,
    input  logic [OFS_W-1:0] ofs_af,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam logic [OCC_W:0] DEPTH_V = (OCC_W + 1)'(DEPTH);

    logic [OCC_W:0] occ_plus_y;

    // occupancy >= DEPTH - Y rewritten as occupancy + Y >= DEPTH to avoid a borrow
    always_comb begin
        occ_plus_y   = {1'b0, occupancy} + (OCC_W + 1)'(ofs_af);
        almost_empty = enable && (occupancy <= OCC_W'(ofs_ae));
        almost_full  = enable && (occ_plus_y >= DEPTH_V);
    end

endmodule

// File: rtl/fifo_offset_prog.sv
// Top of the flag offset programming controller for a DEPTH-word FIFO.
// Assumes one write clock; the FIFO RAM and pointers live outside this block.
module fifo_offset_prog
    import fop_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int DEF_HI  = 64,
    parameter int DEF_MID = 16,
    parameter int DEF_LO  = 8,
    parameter int OFS_W   = $clog2(DEPTH),
    parameter int OCC_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_a_en,
    input  logic             cfg_b_dat,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs_bits,
    input  logic [OCC_W-1:0] occupancy,
    output logic [OFS_W-1:0] ofs_ae,
    output logic [OFS_W-1:0] ofs_af,
    output logic             prog_done,
    output logic             mode_err,
    output logic             wr_divert,
    output logic             ram_wr_en,
    output logic             almost_empty,
    output logic             almost_full
);

    prog_mode_e       dec_mode;
    prog_mode_e       cur_mode;
    logic [OFS_W-1:0] dec_def;

    fop_mode_decode #(
        .OFS_W(OFS_W), .DEF_HI(DEF_HI), .DEF_MID(DEF_MID), .DEF_LO(DEF_LO)
    ) u_dec (
        .pin_mode(cfg_mode),
        .pin_a   (cfg_a_en),
        .pin_b   (cfg_b_dat),
        .mode    (dec_mode),
        .def_ofs (dec_def)
    );

    fop_loader #(.OFS_W(OFS_W)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (dec_mode),
        .def_in  (dec_def),
        .ser_en_n(cfg_a_en),
        .ser_dat (cfg_b_dat),
        .wr_en   (wr_en),
        .wr_bits (wr_ofs_bits),
        .mode_q  (cur_mode),
        .done_q  (prog_done),
        .err_q   (mode_err),
        .ae_q    (ofs_ae),
        .af_q    (ofs_af)
    );

    fop_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W), .OCC_W(OCC_W)) u_flags (
        .enable      (prog_done),
        .occupancy   (occupancy),
        .ofs_ae      (ofs_ae),
        .ofs_af      (ofs_af),
        .almost_empty(almost_empty),
        .almost_full (almost_full)
    );

    // Steer writes: offset writes are diverted, data writes wait for done
    always_comb begin
        wr_divert = rst_n && wr_en && !prog_done && (cur_mode == PM_PARALLEL);
        ram_wr_en = rst_n && wr_en && prog_done;
    end

endmodule

// File: rtl/fop_checker.sv
// Protocol checks for fifo_offset_prog, attached with bind below.
// Assumes the synchronous active-low reset of the checked block.
module fop_checker #(
    parameter int OFS_W  = 9,
    parameter int OCC_W  = 10,
    parameter int ERR_OF = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [OCC_W-1:0] occupancy,
    input logic [OFS_W-1:0] ofs_ae,
    input logic [OFS_W-1:0] ofs_af,
    input logic             prog_done,
    input logic             mode_err,
    input logic             wr_divert,
    input logic             ram_wr_en,
    input logic             almost_empty,
    input logic             almost_full
);

    localparam logic [OFS_W-1:0] ERR_V = OFS_W'(ERR_OF);

    // R7: nothing leaks out before the offsets exist
    a_r7_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |-> (!almost_empty && !almost_full && !ram_wr_en));

    // R5: an offset write never also stores to RAM, and only happens before done
    a_r5_divert_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        wr_divert |-> (wr_en && !ram_wr_en && !prog_done));

    // R10: done is sticky until the next reset
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> prog_done);

    // R10: loaded offsets never move
    a_r10_offsets_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> ($stable(ofs_ae) && $stable(ofs_af)));

    // R2: a mode error comes with the fallback offsets
    a_r2_err_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (prog_done && ofs_ae == ERR_V && ofs_af == ERR_V));

    // R8: with occupancy zero and done, almost-empty must be set
    a_r8_zero_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && occupancy == '0) |-> almost_empty);

endmodule

bind fifo_offset_prog fop_checker #(
    .OFS_W(OFS_W), .OCC_W(OCC_W), .ERR_OF(DEF_LO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .occupancy   (occupancy),
    .ofs_ae      (ofs_ae),
    .ofs_af      (ofs_af),
    .prog_done   (prog_done),
    .mode_err    (mode_err),
    .wr_divert   (wr_divert),
    .ram_wr_en   (ram_wr_en),
    .almost_empty(almost_empty),
    .almost_full (almost_full)
);

// File: tb/fifo_offset_prog_tb.sv
`timescale 1ns/1ps
module fifo_offset_prog_tb;

    typedef struct packed {
        logic [8:0] ae;
        logic [8:0] af;
        logic       err;
        logic [3:0] rq;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b1, cfg_a_en = 1'b1, cfg_b_dat = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_ofs_bits = '0;
    logic [9:0] occupancy = '0;
    logic [8:0] ofs_ae, ofs_af;
    logic       prog_done, mode_err, wr_divert, ram_wr_en, almost_empty, almost_full;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    bit   done_seen = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    fifo_offset_prog u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_a_en(cfg_a_en),
        .cfg_b_dat(cfg_b_dat), .wr_en(wr_en), .wr_ofs_bits(wr_ofs_bits),
        .occupancy(occupancy), .ofs_ae(ofs_ae), .ofs_af(ofs_af),
        .prog_done(prog_done), .mode_err(mode_err), .wr_divert(wr_divert),
        .ram_wr_en(ram_wr_en), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: on each completed programming, pop and compare the expected offsets
    always @(negedge clk) begin
        if (!prog_done) done_seen <= 1'b0;
        else if (!done_seen) begin
            done_seen <= 1'b1;
            if (exp_q.size() == 0) check("R10 unexpected done", 1, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check($sformatf("R%0d offset X", e.rq), 32'(ofs_ae), 32'(e.ae));
                check($sformatf("R%0d offset Y", e.rq), 32'(ofs_af), 32'(e.af));
                check($sformatf("R%0d mode_err", e.rq), 32'(mode_err), 32'(e.err));
            end
        end
    end

    // Hold reset for three cycles with the given mode pins, then release
    task automatic do_reset(input logic m, input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        cfg_mode = m; cfg_a_en = a; cfg_b_dat = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cfg_a_en = 1'b1; cfg_b_dat = 1'b0;
    endtask

    task automatic flag_probe(input logic [9:0] occ, input logic ae_exp, input logic af_exp);
        @(negedge clk);
        occupancy = occ;
        #1;
        check("R8 almost_empty", 32'(almost_empty), 32'(ae_exp));
        check("R9 almost_full", 32'(almost_full), 32'(af_exp));
    endtask

    task automatic par_write(input logic [8:0] d, input logic div_exp, input logic ram_exp);
        @(negedge clk);
        wr_en = 1'b1; wr_ofs_bits = d;
        #1;
        check("R5 wr_divert", 32'(wr_divert), 32'(div_exp));
        check("R5 ram_wr_en", 32'(ram_wr_en), 32'(ram_exp));
        @(negedge clk);
        wr_en = 1'b0; wr_ofs_bits = 9'h1FF;
    endtask

    initial begin
        logic [8:0] sy, sx;
        // R10: reset state
        repeat (2) @(negedge clk);
        check("R10 reset done", 32'(prog_done), 0);
        check("R10 reset X", 32'(ofs_ae), 0);
        check("R10 reset err", 32'(mode_err), 0);

        // R1: presets
        exp_q.push_back('{ae: 9'd64, af: 9'd64, err: 1'b0, rq: 4'd1});
        do_reset(1, 1, 1);
        @(negedge clk);
        check("R1 done after one edge", 32'(prog_done), 1);
        flag_probe(10'd64, 1, 0);
        flag_probe(10'd65, 0, 0);
        flag_probe(10'd447, 0, 0);
        flag_probe(10'd448, 0, 1);
        exp_q.push_back('{ae: 9'd16, af: 9'd16, err: 1'b0, rq: 4'd1});
        do_reset(1, 1, 0);
        repeat (2) @(negedge clk);
        exp_q.push_back('{ae: 9'd8, af: 9'd8, err: 1'b0, rq: 4'd1});
        do_reset(1, 0, 1);
        repeat (2) @(negedge clk);

        // R2: reserved patterns
        exp_q.push_back('{ae: 9'd8, af: 9'd8, err: 1'b1, rq: 4'd2});
        do_reset(0, 0, 0);
        repeat (2) @(negedge clk);
        exp_q.push_back('{ae: 9'd8, af: 9'd8, err: 1'b1, rq: 4'd2});
        do_reset(0, 1, 1);
        repeat (2) @(negedge clk);

        // R10: only the last reset cycle picks the mode
        exp_q.push_back('{ae: 9'd8, af: 9'd8, err: 1'b0, rq: 4'd10});
        @(negedge clk);
        rst_n = 1'b0; cfg_mode = 1; cfg_a_en = 1; cfg_b_dat = 1;
        repeat (2) @(negedge clk);
        cfg_a_en = 0;
        @(negedge clk);
        rst_n = 1'b1; cfg_a_en = 1; cfg_b_dat = 0;
        repeat (2) @(negedge clk);

        // R3, R4, R5, R7: parallel loading with idle gaps
        exp_q.push_back('{ae: 9'd3, af: 9'd500, err: 1'b0, rq: 4'd3});
        do_reset(1, 0, 0);
        occupancy = 10'd0;
        @(negedge clk);
        #1;
        check("R7 no flag before done", 32'(almost_empty), 0);
        check("R3 idle keeps done low", 32'(prog_done), 0);
        par_write(9'd500, 1, 0);
        check("R3 one write not done", 32'(prog_done), 0);
        par_write(9'd3, 1, 0);
        check("R3 done after two writes", 32'(prog_done), 1);
        par_write(9'd77, 0, 1);
        flag_probe(10'd3, 1, 0);
        flag_probe(10'd4, 0, 0);
        flag_probe(10'd11, 0, 0);
        flag_probe(10'd12, 0, 1);
        // R4: MSB-only and LSB-only patterns
        exp_q.push_back('{ae: 9'd1, af: 9'd256, err: 1'b0, rq: 4'd4});
        do_reset(1, 0, 0);
        par_write(9'h100, 1, 0);
        par_write(9'h001, 1, 0);

        // R6: serial loading with a pause carrying a wrong bit
        sy = 9'd300; sx = 9'd5;
        exp_q.push_back('{ae: sx, af: sy, err: 1'b0, rq: 4'd6});
        do_reset(0, 1, 0);
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            if (i == 9) begin
                cfg_a_en = 1'b1; cfg_b_dat = ~sx[8];
                wr_en = 1'b1;
                #1;
                check("R7 serial ram_wr_en", 32'(ram_wr_en), 0);
                check("R6 serial no divert", 32'(wr_divert), 0);
                @(negedge clk);
                wr_en = 1'b0;
            end
            if (i == 17) check("R6 not done at 17 bits", 32'(prog_done), 0);
            cfg_a_en = 1'b0;
            cfg_b_dat = (i < 9) ? sy[8 - i] : sx[17 - i];
        end
        @(negedge clk);
        cfg_a_en = 1'b1;
        check("R6 done after 18 bits", 32'(prog_done), 1);
        flag_probe(10'd211, 0, 0);
        flag_probe(10'd212, 0, 1);
        flag_probe(10'd5, 1, 0);
        flag_probe(10'd6, 0, 0);

        repeat (3) @(negedge clk);
        check("R10 all programmings seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule